// File: doc/BRIEF.md
# Interrupt Routing Register Bank

This block holds the routing target for every interrupt of an extended shared-interrupt range. Each entry is a 64-bit register that names one processor through four 8-bit affinity levels, plus a mode bit. The mode bit chooses between delivery to that one processor and delivery to any participating processor. Software reaches the bank through a simple register bus with a single-cycle valid/ready handshake. The bus accepts either full 64-bit accesses or 32-bit accesses to one half of a register.

Every access is filtered before it touches storage. The access reads as zero and its write is dropped in any of these cases: the address lies outside the bank, the extended range is absent, the entry lies beyond the configured range size, affinity routing is off for the interrupt's security state, or a non-secure requester targets a secure interrupt while security is enabled. Reserved bits always read as zero. The distribution logic reads each entry's target through a separate read-only side port indexed by interrupt number.

Top module: `irr_bank`

## Requirements
- R1: After reset every entry reads as zero on the bus, and the side port returns affinity 0 and mode 0.
- R2: Register layout: bits [7:0], [15:8] and [23:16] are affinity levels 0, 1 and 2, bit 31 is the mode, and bits [39:32] are affinity level 3. Bits [30:24] and [63:40] always read zero and ignore writes.
- R3: Entry n sits at byte address BASE + 8*n. When the size input is 0, the access is 32 bits wide and address bit 2 picks the half: 0 for bits [31:0], 1 for bits [63:32], carried on data bits [31:0]. Addresses outside the bank read zero and ignore writes.
- R4: When the range-present input is 0, every entry reads zero and ignores writes.
- R5: Only entries below (range+1)*32 are implemented. Entries at or above that count read zero and ignore writes.
- R6: When security-disable is 0, a non-secure access to an entry whose group input is 0 (Group 0 or Secure Group 1) reads zero and ignores writes. Secure accesses, and all accesses when security-disable is 1, proceed.
- R7: An entry whose group input is 1 uses the non-secure routing enable, and any other entry uses the secure one. While that enable is 0 the entry reads zero and ignores writes.
- R8: The mode bit is writable and reads back as written.
- R9: While an entry's stored mode bit is 1, writes to its affinity fields are ignored. The mode bit itself stays writable.
- R10: While the one-of-N-unsupported input is 1, a write of 1 to the mode bit stores 0.
- R11: The side port returns the stored affinity as {level3, level2, level1, level0} and the mode of entry rt_idx, one cycle after rt_idx is presented.
- R12: The read response (rsp_valid with rsp_rdata) appears exactly two clock edges after the edge that accepts the read. Writes take effect at the accepting edge and produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus ready, always 1 |
| req_write | input | 1 | 1 for write, 0 for read |
| req_full | input | 1 | 1 for 64-bit access, 0 for 32-bit half access |
| req_nonsecure | input | 1 | Requester is non-secure |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| cfg_range_present | input | 1 | Extended range implemented |
| cfg_range | input | 5 | Range size, (value+1)*32 entries |
| cfg_sec_disable | input | 1 | Single security state |
| cfg_route_en_s | input | 1 | Affinity routing enable, secure |
| cfg_route_en_ns | input | 1 | Affinity routing enable, non-secure |
| cfg_one_of_n_unsup | input | 1 | One-of-N routing unsupported |
| int_ns_grp1 | input | 1024 | Per interrupt: 1 = non-secure Group 1 |
| rt_idx | input | 10 | Side-port interrupt index |
| rt_affinity | output | 32 | Side-port affinity {L3,L2,L1,L0} |
| rt_mode | output | 1 | Side-port routing mode |

## Verification
A write is driven for one cycle and is committed at its accepting edge, so the next request already sees the result. Read data is due two edges after acceptance. The bench samples rsp_valid at the falling edge after the first edge, where it must be low, and at the falling edge after the second, where the data must be present. Side-port results are due one edge after rt_idx changes, and they are sampled at the following falling edge. Each ignored write is confirmed by reading the entry back through the bus or the side port after the permission has been restored.

// File: rtl/irr_pkg.sv
package irr_pkg;
  typedef struct packed {
    logic [7:0] l3;
    logic [7:0] l2;
    logic [7:0] l1;
    logic [7:0] l0;
  } aff_t;

  function automatic logic [63:0] to_reg64(aff_t a, logic mode);
    return {24'b0, a.l3, mode, 7'b0, a.l2, a.l1, a.l0};
  endfunction
endpackage

// File: rtl/irr_decode.sv
module irr_decode import irr_pkg::*; #(
  parameter int NUM_REGS = 1024,
  parameter int ADDR_W   = 16,
  parameter int RANGE_W  = 5,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h8000,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_full,
  input  logic              req_nonsecure,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  input  logic              cfg_range_present,
  input  logic [RANGE_W-1:0] cfg_range,
  input  logic              cfg_sec_disable,
  input  logic              cfg_route_en_s,
  input  logic              cfg_route_en_ns,
  input  logic              cfg_one_of_n_unsup,
  input  logic [NUM_REGS-1:0] int_ns_grp1,
  input  logic              mode_cur,
  output logic [IDX_W-1:0]  idx,
  output logic              allowed,
  output logic              rd_fire,
  output logic              upper_half,
  output logic [3:0]        aff_be,
  output aff_t              aff_wd,
  output logic              mode_we,
  output logic              mode_wd
);
  localparam longint WIN_BYTES = longint'(NUM_REGS) * 8;

  logic [31:0] off;
  logic        hit, in_range, sec_ok, route_ok, ns_int;
  logic        wr, lo_sel, hi_sel;

  always_comb begin
    off      = 32'(req_addr) - 32'(BASE_ADDR);
    hit      = (req_addr >= BASE_ADDR) && (longint'(off) < WIN_BYTES);
    idx      = off[IDX_W+2:3];
    ns_int   = int_ns_grp1[idx];
    in_range = (32'(idx) < ((32'(cfg_range) + 32'd1) << 5));
    sec_ok   = cfg_sec_disable || !req_nonsecure || ns_int;
    route_ok = ns_int ? cfg_route_en_ns : cfg_route_en_s;
    allowed  = hit && cfg_range_present && in_range && sec_ok && route_ok;
    upper_half = req_addr[2];
    lo_sel   = req_full || !upper_half;
    hi_sel   = req_full || upper_half;
    wr       = req_valid && req_write && allowed;
    rd_fire  = req_valid && !req_write;
    aff_be   = {wr && hi_sel && !mode_cur, {3{wr && lo_sel && !mode_cur}}};
    aff_wd.l0 = req_wdata[7:0];
    aff_wd.l1 = req_wdata[15:8];
    aff_wd.l2 = req_wdata[23:16];
    aff_wd.l3 = req_full ? req_wdata[39:32] : req_wdata[7:0];
    mode_we  = wr && lo_sel;
    mode_wd  = req_wdata[31] && !cfg_one_of_n_unsup;
  end
endmodule

// File: rtl/irr_store.sv
module irr_store import irr_pkg::*; #(
  parameter int NUM_REGS = 1024,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic [3:0]       aff_be,
  input  aff_t             aff_wd,
  input  logic             mode_we,
  input  logic             mode_wd,
  input  logic             unsup_chk,
  output logic             mode_cur,
  output aff_t             rd_aff,
  output logic             rd_mode,
  input  logic [IDX_W-1:0] rt_idx,
  output logic [31:0]      rt_affinity,
  output logic             rt_mode
);
  logic [31:0]         mem [NUM_REGS];
  logic [NUM_REGS-1:0] filled;
  logic [NUM_REGS-1:0] mode_q;
  logic [31:0]         rd_q, side_q;
  logic                rd_fill_q, side_fill_q;
  logic [3:0]          be_eff;
  logic [31:0]         wd_eff;

  assign mode_cur = mode_q[idx];

  // First write to an entry fills all bytes so unwritten ones read zero
  always_comb begin
    for (int b = 0; b < 4; b++) begin
      be_eff[b] = (|aff_be) && (aff_be[b] || !filled[idx]);
      wd_eff[b*8 +: 8] = aff_be[b] ? aff_wd[b*8 +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < 4; b++)
      if (be_eff[b]) mem[idx][b*8 +: 8] <= wd_eff[b*8 +: 8];
    rd_q   <= mem[idx];
    side_q <= mem[rt_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      filled      <= '0;
      mode_q      <= '0;
      rd_fill_q   <= 1'b0;
      rd_mode     <= 1'b0;
      side_fill_q <= 1'b0;
      rt_mode     <= 1'b0;
    end else begin
      if (|aff_be) filled[idx] <= 1'b1;
      if (mode_we) mode_q[idx] <= mode_wd;
      rd_fill_q   <= filled[idx];
      rd_mode     <= mode_q[idx];
      side_fill_q <= filled[rt_idx];
      rt_mode     <= mode_q[rt_idx];
    end
  end

  assign rd_aff      = rd_fill_q ? aff_t'(rd_q) : '0;
  assign rt_affinity = side_fill_q ? side_q : 32'h0;

  assert_lock_aff_R9: assert property (@(posedge clk) disable iff (rst)
    (|aff_be) |-> !mode_q[idx]);

  assert_unsup_mode_R10: assert property (@(posedge clk) disable iff (rst)
    (mode_we && unsup_chk) |=> !mode_q[$past(idx)]);
endmodule

// File: rtl/irr_resp.sv
module irr_resp import irr_pkg::*; (
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_fire,
  input  logic        allowed,
  input  logic        req_full,
  input  logic        upper_half,
  input  aff_t        rd_aff,
  input  logic        rd_mode,
  output logic        rsp_valid,
  output logic [63:0] rsp_rdata
);
  logic        p_valid, p_allowed, p_full, p_upper;
  logic [63:0] word;

  always_comb begin
    word = p_allowed ? to_reg64(rd_aff, rd_mode) : 64'h0;
    if (!p_full) word = p_upper ? {32'h0, word[63:32]} : {32'h0, word[31:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_valid   <= 1'b0;
      p_allowed <= 1'b0;
      p_full    <= 1'b0;
      p_upper   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= 64'h0;
    end else begin
      p_valid   <= rd_fire;
      p_allowed <= allowed;
      p_full    <= req_full;
      p_upper   <= upper_half;
      rsp_valid <= p_valid;
      rsp_rdata <= p_valid ? word : 64'h0;
    end
  end

  assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_rdata[63:40] == 24'h0 && rsp_rdata[30:24] == 7'h0));
endmodule

// File: rtl/irr_bank.sv
module irr_bank import irr_pkg::*; #(
  parameter int NUM_REGS = 1024,
  parameter int ADDR_W   = 16,
  parameter int RANGE_W  = 5,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h8000,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic                req_full,
  input  logic                req_nonsecure,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [63:0]         req_wdata,
  output logic                rsp_valid,
  output logic [63:0]         rsp_rdata,
  input  logic                cfg_range_present,
  input  logic [RANGE_W-1:0]  cfg_range,
  input  logic                cfg_sec_disable,
  input  logic                cfg_route_en_s,
  input  logic                cfg_route_en_ns,
  input  logic                cfg_one_of_n_unsup,
  input  logic [NUM_REGS-1:0] int_ns_grp1,
  input  logic [IDX_W-1:0]    rt_idx,
  output logic [31:0]         rt_affinity,
  output logic                rt_mode
);
  logic [IDX_W-1:0] idx;
  logic             allowed, rd_fire, upper_half, mode_cur, mode_we, mode_wd, rd_mode;
  logic [3:0]       aff_be;
  aff_t             aff_wd, rd_aff;

  assign req_ready = 1'b1;

  irr_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .RANGE_W(RANGE_W),
               .BASE_ADDR(BASE_ADDR)) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_full(req_full),
    .req_nonsecure(req_nonsecure), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_range_present(cfg_range_present), .cfg_range(cfg_range),
    .cfg_sec_disable(cfg_sec_disable), .cfg_route_en_s(cfg_route_en_s),
    .cfg_route_en_ns(cfg_route_en_ns), .cfg_one_of_n_unsup(cfg_one_of_n_unsup),
    .int_ns_grp1(int_ns_grp1), .mode_cur(mode_cur), .idx(idx), .allowed(allowed),
    .rd_fire(rd_fire), .upper_half(upper_half), .aff_be(aff_be), .aff_wd(aff_wd),
    .mode_we(mode_we), .mode_wd(mode_wd));

  irr_store #(.NUM_REGS(NUM_REGS)) u_store (
    .clk(clk), .rst(rst), .idx(idx), .aff_be(aff_be), .aff_wd(aff_wd),
    .mode_we(mode_we), .mode_wd(mode_wd), .unsup_chk(cfg_one_of_n_unsup),
    .mode_cur(mode_cur), .rd_aff(rd_aff), .rd_mode(rd_mode), .rt_idx(rt_idx),
    .rt_affinity(rt_affinity), .rt_mode(rt_mode));

  irr_resp u_resp (
    .clk(clk), .rst(rst), .rd_fire(rd_fire), .allowed(allowed),
    .req_full(req_full), .upper_half(upper_half), .rd_aff(rd_aff),
    .rd_mode(rd_mode), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

  assert_rsp_latency_R12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> ##1 rsp_valid);

  assert_absent_nowrite_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !cfg_range_present) |-> (aff_be == 4'h0 && !mode_we));
endmodule

// File: tb/sim_irr_bank.sv
module sim_irr_bank;
  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0, req_full = 1, req_nonsecure = 1;
  logic [15:0] req_addr = 0;
  logic [63:0] req_wdata = 0;
  logic req_ready, rsp_valid, rt_mode;
  logic [63:0] rsp_rdata;
  logic cfg_range_present = 1, cfg_sec_disable = 0;
  logic cfg_route_en_s = 1, cfg_route_en_ns = 1, cfg_one_of_n_unsup = 0;
  logic [4:0] cfg_range = 5'd31;
  logic [1023:0] int_ns_grp1 = '1;
  logic [9:0] rt_idx = 0;
  logic [31:0] rt_affinity;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irr_bank u0 (.*);

  function automatic logic [15:0] ad(int n);
    return 16'(32'h8000 + 8 * n);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [63:0] d, logic full = 1, logic ns = 1);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    req_full = full; req_nonsecure = ns;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(logic [15:0] a, output logic [63:0] d, input logic full = 1, logic ns = 1);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_full = full; req_nonsecure = ns;
    @(negedge clk);
    req_valid = 0;
    chk("R12 early", 64'(rsp_valid), 64'd0);
    @(negedge clk);
    chk("R12 due", 64'(rsp_valid), 64'd1);
    d = rsp_rdata;
  endtask

  task automatic side(int n, output logic [31:0] a, output logic m);
    @(negedge clk);
    rt_idx = 10'(n);
    @(negedge clk);
    a = rt_affinity; m = rt_mode;
  endtask

  task automatic t_reset();
    logic [63:0] d; logic [31:0] a; logic m;
    rd(ad(0), d); chk("R1 entry0", d, 0);
    rd(ad(1023), d); chk("R1 entry1023", d, 0);
    side(5, a, m); chk("R1 side", {a, 31'b0, m}, 0);
  endtask

  task automatic t_layout();
    logic [63:0] d;
    wr(ad(3), 64'hFFFFFFAB_7FC1D2E3);
    rd(ad(3), d); chk("R2 reserved masked", d, 64'h000000AB_00C1D2E3);
  endtask

  task automatic t_halves();
    logic [63:0] d;
    wr(ad(7) + 16'd4, 64'h12, 0);
    rd(ad(7), d); chk("R3 hi-half write", d, 64'h00000012_00000000);
    rd(ad(7), d, 0); chk("R3 lo-half read", d, 0);
    rd(ad(7) + 16'd4, d, 0); chk("R3 hi-half read", d, 64'h12);
    wr(ad(7), 64'h00A0B0C0, 0);
    rd(ad(7), d); chk("R3 lo-half write", d, 64'h00000012_00A0B0C0);
    rd(16'hA000, d); chk("R3 past window", d, 0);
    wr(16'h7FF8, 64'h55);
    rd(16'h7FF8, d); chk("R3 below window", d, 0);
  endtask

  task automatic t_absent();
    logic [63:0] d;
    cfg_range_present = 0;
    wr(ad(10), 64'h44);
    rd(ad(10), d); chk("R4 absent read", d, 0);
    cfg_range_present = 1;
    rd(ad(10), d); chk("R4 write ignored", d, 0);
  endtask

  task automatic t_range();
    logic [63:0] d;
    cfg_range = 0;
    wr(ad(31), 64'h31); wr(ad(32), 64'h32);
    rd(ad(31), d); chk("R5 last implemented", d, 64'h31);
    rd(ad(32), d); chk("R5 beyond range", d, 0);
    cfg_range = 31;
    rd(ad(32), d); chk("R5 write ignored", d, 0);
  endtask

  task automatic t_secure();
    logic [63:0] d;
    int_ns_grp1[40] = 0;
    wr(ad(40), 64'h11, 1, 1);
    rd(ad(40), d, 1, 1); chk("R6 ns read of secure", d, 0);
    rd(ad(40), d, 1, 0); chk("R6 ns write ignored", d, 0);
    wr(ad(40), 64'h22, 1, 0);
    rd(ad(40), d, 1, 0); chk("R6 secure access", d, 64'h22);
    rd(ad(40), d, 1, 1); chk("R6 ns still blocked", d, 0);
    cfg_sec_disable = 1;
    rd(ad(40), d, 1, 1); chk("R6 security disabled", d, 64'h22);
    cfg_sec_disable = 0;
  endtask

  task automatic t_route_en();
    logic [63:0] d;
    cfg_route_en_s = 0;
    rd(ad(40), d, 1, 0); chk("R7 secure routing off", d, 0);
    wr(ad(40), 64'h33, 1, 0);
    rd(ad(3), d); chk("R7 ns entry unaffected", d, 64'h000000AB_00C1D2E3);
    cfg_route_en_s = 1;
    rd(ad(40), d, 1, 0); chk("R7 write ignored", d, 64'h22);
    cfg_route_en_ns = 0;
    rd(ad(3), d); chk("R7 ns routing off", d, 0);
    cfg_route_en_ns = 1;
  endtask

  task automatic t_mode();
    logic [63:0] d;
    wr(ad(13), 64'h80000001);
    rd(ad(13), d); chk("R8 mode readback", d, 64'h80000001);
  endtask

  task automatic t_lock();
    logic [63:0] d;
    wr(ad(9), 64'h05_00000102);
    wr(ad(9), 64'h80000304, 0);
    rd(ad(9), d); chk("R9 set mode with affinity", d, 64'h05_80000304);
    wr(ad(9), 64'h77_80000506);
    rd(ad(9), d); chk("R9 full write locked", d, 64'h05_80000304);
    wr(ad(9) + 16'd4, 64'h66, 0);
    rd(ad(9), d); chk("R9 hi write locked", d, 64'h05_80000304);
    wr(ad(9), 64'h00000708, 0);
    rd(ad(9), d); chk("R9 mode cleared", d, 64'h05_00000304);
    wr(ad(9), 64'h00000708, 0);
    rd(ad(9), d); chk("R9 unlocked", d, 64'h05_00000708);
  endtask

  task automatic t_unsup();
    logic [63:0] d;
    cfg_one_of_n_unsup = 1;
    wr(ad(12), 64'h800000AA);
    rd(ad(12), d); chk("R10 mode held 0", d, 64'hAA);
    cfg_one_of_n_unsup = 0;
  endtask

  task automatic t_side();
    logic [31:0] a; logic m;
    side(9, a, m); chk("R11 affinity entry9", 64'(a), 64'h05000708);
    chk("R11 mode entry9", 64'(m), 0);
    side(13, a, m); chk("R11 affinity entry13", 64'(a), 64'h1);
    chk("R11 mode entry13", 64'(m), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 rsp idle", {rsp_valid, rsp_rdata[62:0]}, 0);
    t_reset(); t_layout(); t_halves(); t_absent(); t_range();
    t_secure(); t_route_en(); t_mode(); t_lock(); t_unsup(); t_side();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule